// File: doc/BRIEF.md
# Linked-Load / Store-Conditional Reservation Controller

This block sits beside an L1 cache controller and serves linked-load (LL) and store-conditional (SC) requests from one processor. No reservation is ever sent into the network. The block keeps one local reservation entry instead. The entry holds a word address, the value that the linked load returned, a valid flag and a width flag that marks a 64-bit access.

A linked load that finds a matching reservation spins locally and is answered from the entry. Any other linked load arms the entry and fetches the word with an ordinary read. A store-conditional that matches the entry becomes an SC packet for the memory-side controller. The packet carries the loaded value first and the new value after it, so the memory side can decide the outcome by comparing values. The block then passes that controller's verdict back to the processor. A store-conditional that does not match fails at once.

Every store-conditional consumes the reservation. Invalidations and updates from the coherence side leave the reservation untouched.

Top module: `llsc_resv_ctrl`

## Requirements
- R1: After reset, req_ready_o is high and rsp_valid_o, rd_req_valid_o and sc_flit_valid_o are low. The reservation starts empty, so the first SC fails locally.
- R2: A request with req_op_i = 0 is an LL. When the reservation is valid and matches both req_addr_i and req_long_i, rsp_valid_o rises in the cycle after acceptance. rsp_data_o then carries the stored value, rsp_fail_o is 0, and no read request is issued.
- R3: An LL that misses issues one read whose rd_addr_o and rd_long_o equal the request. The read is held while rd_req_ready_i is low. The response data is rd_rsp_data_i for a 64-bit access, or its low FLIT_W bits with the upper half zero for a 32-bit access. The reservation is armed with that address, width and data.
- R4: An SC (req_op_i = 1) that hits emits 4 flits for a 64-bit access and 2 flits for a 32-bit access. The order is: stored value low word, stored value high word (64-bit only), new value low word, new value high word (64-bit only). sc_flit_last_o is set only on the final flit, and sc_addr_o equals the address. Each flit is held while sc_flit_ready_i is low.
- R5: After an SC packet, the bit on sc_rsp_fail_i (0 success, 1 failure) appears on rsp_fail_o together with rsp_valid_o, in the cycle after sc_rsp_valid_i. rsp_data_o is zero for SC responses.
- R6: An SC whose address or width differs from a valid reservation, or that finds no reservation, answers rsp_fail_o = 1 in the cycle after acceptance and emits no flit.
- R7: Every SC, hit or miss, clears the reservation. A following LL to the same address and width goes to the network.
- R8: A pulse on coh_valid_i, for any address, leaves the reservation unchanged. A matching LL after it is still a local spin that returns the old value.
- R9: Only one request is in flight at a time. req_ready_o is low from the cycle after acceptance through the response cycle, and it is high again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_op_i | input | 1 | 0 linked load, 1 store-conditional |
| req_long_i | input | 1 | 1 for a 64-bit access |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | 2*FLIT_W | Store-conditional data |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_data_o | output | 2*FLIT_W | LL data, zero for SC |
| rsp_fail_o | output | 1 | SC outcome, 1 failure |
| rd_req_valid_o | output | 1 | Network read request |
| rd_req_ready_i | input | 1 | Read request accepted |
| rd_addr_o | output | ADDR_W | Read address |
| rd_long_o | output | 1 | Read width, 1 for 64 bits |
| rd_rsp_valid_i | input | 1 | Read data strobe |
| rd_rsp_data_i | input | 2*FLIT_W | Read data |
| sc_flit_valid_o | output | 1 | SC packet flit valid |
| sc_flit_ready_i | input | 1 | Flit accepted |
| sc_flit_data_o | output | FLIT_W | Flit payload |
| sc_flit_last_o | output | 1 | Final flit of the packet |
| sc_addr_o | output | ADDR_W | Address of the SC packet |
| sc_rsp_valid_i | input | 1 | Memory-side SC verdict strobe |
| sc_rsp_fail_i | input | 1 | Verdict, 0 success, 1 failure |
| coh_valid_i | input | 1 | Invalidate or update for a line |
| coh_addr_i | input | ADDR_W | Address of that event |

## Verification
The assertions assume a few things about the neighbours. The network and the memory side answer only while the block is waiting for them. A read response never arrives in the same cycle the read request is accepted. The processor raises a new request only when ready is high. The bench drives every input at the falling edge. Its read and packet responders answer only after they see a handshake, with a configurable stall, so none of these assumptions is broken. Processor requests are issued strictly one after another. Coherence pulses are placed only between requests, while the block is idle.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_SC_SEND, ST_SC_WAIT, ST_RESP
  } ctrl_state_e;

  localparam logic OP_LL = 1'b0;
  localparam logic OP_SC = 1'b1;
endpackage

// File: rtl/llsc_resv_reg.sv
module llsc_resv_reg #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [ADDR_W-1:0] arm_addr_i,
  input  logic              arm_long_i,
  input  logic              fill_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              drop_i,
  input  logic [ADDR_W-1:0] qry_addr_i,
  input  logic              qry_long_i,
  input  logic              coh_valid_i,
  input  logic [ADDR_W-1:0] coh_addr_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              long_o,
  output logic [DATA_W-1:0] data_o
);
  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic              long_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      long_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      if (drop_i)     valid_q <= 1'b0;
      else if (arm_i) valid_q <= 1'b1;
      if (arm_i) begin
        addr_q <= arm_addr_i;
        long_q <= arm_long_i;
      end
      if (fill_i) data_q <= fill_data_i;
    end
  end

  // width must match too: a 64-bit entry never serves a 32-bit access
  assign hit_o  = valid_q && (addr_q == qry_addr_i) && (long_q == qry_long_i);
  assign addr_o = addr_q;
  assign long_o = long_q;
  assign data_o = data_q;

  // R8
  coh_keeps_resv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coh_valid_i && (coh_addr_i == addr_q) && !arm_i && !drop_i && !fill_i)
      |=> ($stable(valid_q) && $stable(data_q)));

  // R7
  drop_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> !valid_q);
endmodule

// File: rtl/llsc_sc_packer.sv
module llsc_sc_packer #(
  parameter int FLIT_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [2*FLIT_W-1:0] new_i,
  input  logic [2*FLIT_W-1:0] old_i,
  input  logic                long_i,
  input  logic                flit_ready_i,
  output logic                flit_valid_o,
  output logic [FLIT_W-1:0]   flit_data_o,
  output logic                flit_last_o,
  output logic                done_o
);
  localparam int HALVES = 2;

  logic                busy_q;
  logic [1:0]          idx_q;
  logic [2*FLIT_W-1:0] new_q;
  logic [FLIT_W-1:0]   old_w [HALVES];
  logic [FLIT_W-1:0]   new_w [HALVES];
  logic                sel_new, part;

  for (genvar g = 0; g < HALVES; g++) begin : g_split
    assign old_w[g] = old_i[g*FLIT_W +: FLIT_W];
    assign new_w[g] = new_q[g*FLIT_W +: FLIT_W];
  end

  assign sel_new      = long_i ? idx_q[1] : idx_q[0];
  assign part         = long_i & idx_q[0];
  assign flit_data_o  = sel_new ? new_w[part] : old_w[part];
  assign flit_last_o  = busy_q && (idx_q == (long_i ? 2'd3 : 2'd1));
  assign flit_valid_o = busy_q;
  assign done_o       = busy_q && flit_ready_i && flit_last_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      new_q  <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      new_q  <= new_i;
    end else if (busy_q && flit_ready_i) begin
      if (flit_last_o) busy_q <= 1'b0;
      else             idx_q  <= idx_q + 2'd1;
    end
  end

  // R4
  flit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flit_valid_o && !flit_ready_i) |=>
      (flit_valid_o && $stable(flit_data_o) && $stable(flit_last_o)));

  // R4
  last_ends_pkt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flit_valid_o && flit_ready_i && flit_last_o) |=> !flit_valid_o);
endmodule

// File: rtl/llsc_resv_ctrl.sv
module llsc_resv_ctrl
  import llsc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int FLIT_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_op_i,
  input  logic                req_long_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [2*FLIT_W-1:0] req_wdata_i,
  output logic                rsp_valid_o,
  output logic [2*FLIT_W-1:0] rsp_data_o,
  output logic                rsp_fail_o,
  output logic                rd_req_valid_o,
  input  logic                rd_req_ready_i,
  output logic [ADDR_W-1:0]   rd_addr_o,
  output logic                rd_long_o,
  input  logic                rd_rsp_valid_i,
  input  logic [2*FLIT_W-1:0] rd_rsp_data_i,
  output logic                sc_flit_valid_o,
  input  logic                sc_flit_ready_i,
  output logic [FLIT_W-1:0]   sc_flit_data_o,
  output logic                sc_flit_last_o,
  output logic [ADDR_W-1:0]   sc_addr_o,
  input  logic                sc_rsp_valid_i,
  input  logic                sc_rsp_fail_i,
  input  logic                coh_valid_i,
  input  logic [ADDR_W-1:0]   coh_addr_i
);
  localparam int DATA_W = 2 * FLIT_W;

  ctrl_state_e       state_q, state_d;
  logic              acc, is_sc, hit, pkt_done;
  logic              arm, drop, fill, load;
  logic [DATA_W-1:0] fill_data, resv_data;
  logic [ADDR_W-1:0] resv_addr;
  logic              resv_long;
  logic [DATA_W-1:0] rsp_data_q;
  logic              rsp_fail_q;

  assign req_ready_o    = (state_q == ST_IDLE);
  assign acc            = req_valid_i && req_ready_o;
  assign is_sc          = (req_op_i == OP_SC);
  assign arm            = acc && !is_sc && !hit;
  assign drop           = acc && is_sc;
  assign load           = acc && is_sc && hit;
  assign fill           = (state_q == ST_RD_WAIT) && rd_rsp_valid_i;
  assign fill_data      = rd_long_o ? rd_rsp_data_i
                                    : {{FLIT_W{1'b0}}, rd_rsp_data_i[FLIT_W-1:0]};
  assign rd_req_valid_o = (state_q == ST_RD_REQ);
  assign rd_addr_o      = resv_addr;
  assign rd_long_o      = resv_long;
  assign sc_addr_o      = resv_addr;
  assign rsp_valid_o    = (state_q == ST_RESP);
  assign rsp_data_o     = rsp_data_q;
  assign rsp_fail_o     = rsp_fail_q;

  llsc_resv_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_resv (
    .clk_i, .rst_ni,
    .arm_i(arm), .arm_addr_i(req_addr_i), .arm_long_i(req_long_i),
    .fill_i(fill), .fill_data_i(fill_data), .drop_i(drop),
    .qry_addr_i(req_addr_i), .qry_long_i(req_long_i),
    .coh_valid_i, .coh_addr_i,
    .hit_o(hit), .addr_o(resv_addr), .long_o(resv_long), .data_o(resv_data)
  );

  llsc_sc_packer #(.FLIT_W(FLIT_W)) u_pack (
    .clk_i, .rst_ni,
    .load_i(load), .new_i(req_wdata_i), .old_i(resv_data), .long_i(resv_long),
    .flit_ready_i(sc_flit_ready_i), .flit_valid_o(sc_flit_valid_o),
    .flit_data_o(sc_flit_data_o), .flit_last_o(sc_flit_last_o), .done_o(pkt_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (acc) state_d = is_sc ? (hit ? ST_SC_SEND : ST_RESP)
                                           : (hit ? ST_RESP : ST_RD_REQ);
      ST_RD_REQ:  if (rd_req_ready_i) state_d = ST_RD_WAIT;
      ST_RD_WAIT: if (rd_rsp_valid_i) state_d = ST_RESP;
      ST_SC_SEND: if (pkt_done) state_d = ST_SC_WAIT;
      ST_SC_WAIT: if (sc_rsp_valid_i) state_d = ST_RESP;
      ST_RESP:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      rsp_data_q <= '0;
      rsp_fail_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (acc && !is_sc && hit) begin
        rsp_data_q <= resv_data;
        rsp_fail_q <= 1'b0;
      end else if (acc && is_sc && !hit) begin
        rsp_data_q <= '0;
        rsp_fail_q <= 1'b1;
      end else if (fill) begin
        rsp_data_q <= fill_data;
        rsp_fail_q <= 1'b0;
      end else if ((state_q == ST_SC_WAIT) && sc_rsp_valid_i) begin
        rsp_data_q <= '0;
        rsp_fail_q <= sc_rsp_fail_i;
      end
    end
  end

  // R1
  rsp_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (!rd_req_valid_o && !sc_flit_valid_o));

  // R9
  single_flight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> !req_ready_o);

  // R2
  ll_spin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !is_sc && hit) |=> (rsp_valid_o && !rd_req_valid_o && !rsp_fail_o));

  // R6
  sc_local_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && is_sc && !hit) |=> (rsp_valid_o && rsp_fail_o && !sc_flit_valid_o));

  // R3
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_valid_o && !rd_req_ready_i) |=> (rd_req_valid_o && $stable(rd_addr_o)));

  // R5
  sc_verdict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_SC_WAIT) && sc_rsp_valid_i) |=>
      (rsp_valid_o && (rsp_fail_o == $past(sc_rsp_fail_i))));
endmodule

// File: tb/llsc_resv_ctrl_bench.sv
module llsc_resv_ctrl_bench;
  localparam int AW = 8;
  localparam int FW = 32;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_op = 1'b0, req_long = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, rsp_fail;
  logic [DW-1:0] rsp_data;
  logic          rd_req_valid, rd_long;
  logic          rd_req_ready = 1'b0, rd_rsp_valid = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_rsp_data = '0;
  logic          sc_flit_valid, sc_flit_last;
  logic          sc_flit_ready = 1'b0, sc_rsp_valid = 1'b0, sc_rsp_fail = 1'b0;
  logic [FW-1:0] sc_flit_data;
  logic [AW-1:0] sc_addr;
  logic          coh_valid = 1'b0;
  logic [AW-1:0] coh_addr = '0;

  always #5 clk = ~clk;

  llsc_resv_ctrl #(.ADDR_W(AW), .FLIT_W(FW)) u_llsc_resv_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_long_i(req_long), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_fail_o(rsp_fail),
    .rd_req_valid_o(rd_req_valid), .rd_req_ready_i(rd_req_ready),
    .rd_addr_o(rd_addr), .rd_long_o(rd_long),
    .rd_rsp_valid_i(rd_rsp_valid), .rd_rsp_data_i(rd_rsp_data),
    .sc_flit_valid_o(sc_flit_valid), .sc_flit_ready_i(sc_flit_ready),
    .sc_flit_data_o(sc_flit_data), .sc_flit_last_o(sc_flit_last),
    .sc_addr_o(sc_addr), .sc_rsp_valid_i(sc_rsp_valid), .sc_rsp_fail_i(sc_rsp_fail),
    .coh_valid_i(coh_valid), .coh_addr_i(coh_addr)
  );

  int n_chk = 0, n_bad = 0;
  int g_stall = 0;
  bit g_fail = 1'b0;

  task automatic chk(input bit ok, input string rq, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // network read responder
  int            rd_cnt = 0, rd_ver = 0, rd_wait = 0, rd_stall_ctr = 0;
  bit            rd_pend = 1'b0, rd_prev_v = 1'b0;
  logic [AW-1:0] rd_prev_a = '0, rd_seen_a = '0;
  logic          rd_prev_l = 1'b0, rd_seen_l = 1'b0;
  logic [DW-1:0] rd_sent = '0;

  always @(negedge clk) begin
    rd_rsp_valid = 1'b0;
    if (rd_prev_v && rd_req_ready) begin
      rd_cnt++;
      rd_seen_a = rd_prev_a;
      rd_seen_l = rd_prev_l;
      rd_pend   = 1'b1;
      rd_wait   = g_stall;
    end else if (rd_pend) begin
      if (rd_wait == 0) begin
        rd_ver++;
        rd_sent = {32'hE000_0000 + 32'(rd_ver << 8) + 32'(rd_seen_a),
                   32'h1000_0000 + 32'(rd_ver << 8) + 32'(rd_seen_a)};
        rd_rsp_data  = rd_sent;
        rd_rsp_valid = 1'b1;
        rd_pend      = 1'b0;
      end else rd_wait--;
    end
    rd_prev_v = rd_req_valid;
    rd_prev_a = rd_addr;
    rd_prev_l = rd_long;
    if (rd_req_valid) begin
      rd_req_ready = (rd_stall_ctr >= g_stall);
      rd_stall_ctr++;
    end else begin
      rd_req_ready = 1'b0;
      rd_stall_ctr = 0;
    end
  end

  // SC packet collector and verdict source
  int            nfl = 0, sc_wait = 0, fcyc = 0;
  bit            sc_pend = 1'b0, f_prev_v = 1'b0, f_prev_l = 1'b0;
  logic [FW-1:0] f_prev_d = '0;
  logic [AW-1:0] f_prev_a = '0;
  logic [FW-1:0] fl_d [8];
  logic          fl_l [8];
  logic [AW-1:0] fl_a [8];

  always @(negedge clk) begin
    sc_rsp_valid = 1'b0;
    if (f_prev_v && sc_flit_ready) begin
      fl_d[nfl % 8] = f_prev_d;
      fl_l[nfl % 8] = f_prev_l;
      fl_a[nfl % 8] = f_prev_a;
      nfl++;
      if (f_prev_l) begin
        sc_pend = 1'b1;
        sc_wait = g_stall;
      end
    end else if (sc_pend) begin
      if (sc_wait == 0) begin
        sc_rsp_valid = 1'b1;
        sc_rsp_fail  = g_fail;
        sc_pend      = 1'b0;
      end else sc_wait--;
    end
    f_prev_v = sc_flit_valid;
    f_prev_d = sc_flit_data;
    f_prev_l = sc_flit_last;
    f_prev_a = sc_addr;
    fcyc++;
    sc_flit_ready = (g_stall == 0) || (fcyc % 3 != 0);
  end

  // reference model of the reservation
  bit            m_valid = 1'b0, m_long = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_data = '0;

  task automatic wait_rsp(input string rq);
    while (!rsp_valid) begin
      if (req_ready) chk(1'b0, {rq, " R9 ready while busy"}, 64'd1, 64'd0);
      @(negedge clk);
    end
  endtask

  task automatic issue(input logic op, input logic l, input logic [AW-1:0] a,
                       input logic [DW-1:0] w);
    chk(req_ready, "R9 ready when idle", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_op = op; req_long = l; req_addr = a; req_wdata = w;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_ll(input logic l, input logic [AW-1:0] a);
    bit hit = m_valid && (m_addr == a) && (m_long == l);
    int rc0 = rd_cnt;
    logic [DW-1:0] exp;
    issue(1'b0, l, a, '0);
    if (hit) begin
      chk(rsp_valid, "R2 spin answers next cycle", 64'(rsp_valid), 64'd1);
      chk(rsp_data == m_data, "R2 spin data", rsp_data, m_data);
      chk(rd_cnt == rc0, "R2 no network read", 64'(rd_cnt), 64'(rc0));
    end else begin
      wait_rsp("R3");
      exp = l ? rd_sent : {32'd0, rd_sent[31:0]};
      chk(rsp_data == exp, "R3 read data", rsp_data, exp);
      chk(rd_cnt == rc0 + 1, "R3 one read", 64'(rd_cnt), 64'(rc0 + 1));
      chk(rd_seen_a == a && rd_seen_l == l, "R3 read addr/width",
          {55'd0, rd_seen_l, rd_seen_a}, {55'd0, l, a});
      m_valid = 1'b1; m_addr = a; m_long = l; m_data = exp;
    end
    chk(!rsp_fail, "R2 LL not failing", 64'(rsp_fail), 64'd0);
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R9 ready after response", 64'(req_ready), 64'd1);
  endtask

  task automatic do_sc(input logic l, input logic [AW-1:0] a, input logic [DW-1:0] w);
    bit hit = m_valid && (m_addr == a) && (m_long == l);
    int base = nfl;
    int nexp = l ? 4 : 2;
    logic [FW-1:0] ef [4];
    issue(1'b1, l, a, w);
    if (!hit) begin
      chk(rsp_valid && rsp_fail, "R6 local failure next cycle",
          {62'd0, rsp_valid, rsp_fail}, 64'd3);
    end else begin
      if (l) begin
        ef[0] = m_data[31:0]; ef[1] = m_data[63:32]; ef[2] = w[31:0]; ef[3] = w[63:32];
      end else begin
        ef[0] = m_data[31:0]; ef[1] = w[31:0]; ef[2] = '0; ef[3] = '0;
      end
      wait_rsp("R5");
      chk(rsp_fail == g_fail, "R5 verdict passed through", 64'(rsp_fail), 64'(g_fail));
      chk(rsp_data == '0, "R5 SC data zero", rsp_data, 64'd0);
      chk(nfl - base == nexp, "R4 flit count", 64'(nfl - base), 64'(nexp));
      for (int k = 0; k < nexp; k++) begin
        chk(fl_d[(base + k) % 8] == ef[k], "R4 flit payload order",
            64'(fl_d[(base + k) % 8]), 64'(ef[k]));
        chk(fl_l[(base + k) % 8] == (k == nexp - 1), "R4 last flag",
            64'(fl_l[(base + k) % 8]), 64'(k == nexp - 1));
        chk(fl_a[(base + k) % 8] == a, "R4 packet address",
            64'(fl_a[(base + k) % 8]), 64'(a));
      end
    end
    m_valid = 1'b0;  // R7
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R9 ready after response", 64'(req_ready), 64'd1);
    if (!hit) chk(nfl == base, "R6 no flits", 64'(nfl - base), 64'd0);
  endtask

  task automatic do_coh(input logic [AW-1:0] a);
    coh_valid = 1'b1; coh_addr = a;
    @(negedge clk);
    coh_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R9: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(req_ready, "R1 ready after reset", 64'(req_ready), 64'd1);
    chk(!rsp_valid && !rd_req_valid && !sc_flit_valid, "R1 outputs idle",
        {61'd0, rsp_valid, rd_req_valid, sc_flit_valid}, 64'd0);
    do_sc(1'b0, 8'h05, 64'h1);              // R1 empty reservation fails
    do_ll(1'b0, 8'h05);                     // R3 miss
    do_ll(1'b0, 8'h05);                     // R2 spin
    do_coh(8'h05);
    do_coh(8'h33);
    do_ll(1'b0, 8'h05);                     // R8 still a spin
    do_sc(1'b1, 8'h05, 64'h2);              // R6 width mismatch
    do_ll(1'b0, 8'h05);                     // R7 goes to network again
    g_fail = 1'b0;
    do_sc(1'b0, 8'h05, 64'hAAAA_BBBB_CCCC_DDDD); // R4 short packet
    g_stall = 2;
    do_ll(1'b1, 8'h09);
    g_fail = 1'b1;
    do_sc(1'b1, 8'h09, 64'h0123_4567_89AB_CDEF); // R4 R5 long packet, failure
    do_sc(1'b1, 8'h09, 64'h5);              // R7 consumed
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      logic l;
      seed = seed * 32'd1103515245 + 32'd12345;
      a = seed[20] ? 8'h21 : 8'h20;
      l = seed[22];
      g_stall = int'(seed[26:25]);
      g_fail = seed[27];
      case (seed[30:29])
        2'd0, 2'd1: do_ll(l, a);
        2'd2: do_sc(l, a, {seed, ~seed});
        default: begin do_coh(seed[21] ? a : 8'h21); do_ll(l, a); end
      endcase
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule